// File: doc/BRIEF.md
# Windowed Image Sensor Readout Sequencer

This block drives the digital side of an addressable image sensor so that only a rectangular window of pixels is read. A frame begins with a start command. The block then writes the column and row start coordinates into the sensor over one shared address bus. Each coordinate has its own load strobe, and the bus is kept stable before, during and after the strobe. The block then issues the row sync, a single calibration pulse and the per-row strobe sequence. For each row it presets the column shift register with a column sync and clocks out the window's pixels, and it captures the converter word for every pixel.

A start coordinate is written only when it differs from the value loaded in an earlier frame. A loaded value takes effect only at the matching sync pulse. The row coordinate is loaded in the frame head, before the row sync. The column coordinate is loaded in the idle gap of the first row, after the row clock falls and before the first column sync.

All intervals are counts of the system clock and are set by parameters, which are checked at elaboration. Captured words leave as a stream with a valid strobe, a start-of-frame mark and an end-of-row mark.

Top module: `roi_readout_seq`

## Requirements
- R1: After reset, and while idle, every sensor control output, `busy` and `pix_valid` are 0.
- R2: `frame_start` is accepted only when idle with `roi_w` and `roi_h` both nonzero. A start with a zero size, or one given while busy, has no effect.
- R3: A coordinate load places the value on `addr_bus` at least P_ASU cycles before its strobe. The strobe (`ld_col` for the column, `ld_row` for the row) is high for P_ALD cycles. The bus does not change for at least P_AHO cycles after the strobe falls. The two strobes are never high together, and the bus carries the frame's coordinate during its strobe.
- R4: The first frame after reset loads both coordinates. In a later frame, a coordinate equal to the last loaded value gets no strobe. A changed coordinate gets exactly one strobe.
- R5: `ld_row` occurs before the frame's `sync_row`. `ld_col` occurs with `row_clk` low, after the first row clock falls and before the first `sync_col` of the frame.
- R6: `sync_row` is high for P_SYNCY cycles. `cal_pulse` occurs exactly once per frame: it rises P_CALD cycles after `sync_row` falls and stays high for P_CALW cycles.
- R7: Each row runs the following sequence:
  - `row_clk` rises together with `row_select` and `row_read`.
  - `row_select` falls P_SEL cycles later.
  - `row_reset` rises P_RSTD cycles after that and stays high for P_RSTW cycles.
  - `row_read` falls P_RD cycles after `row_reset` falls.
  - `side_sel` rises P_LRD cycles after `row_read` falls and stays high for P_LRW cycles.
  - `row_clk` falls P_CYF cycles after `side_sel` falls.
- R8: `sync_col` is high for P_SX cycles, only while `pix_clk` is high, once per row. Between pixels, `pix_clk` is low for P_XL cycles. It is high for P_XH cycles, or P_SX+P_XH cycles when the high phase contains the sync. `pix_clk` falls once per pixel.
- R9: `adc_clk` equals `pix_clk` at all times. `adc_data` is sampled P_ADC cycles after `adc_clk` falls and appears on `pix_data` with `pix_valid` P_ADC+1 cycles after the fall.
- R10: A frame yields exactly `roi_w`×`roi_h` valid words in row-major order. `pix_sof` is set on the first word only, and `pix_eol` is set on the last word of each row.
- R11: `busy` is 1 from the cycle after an accepted start until the frame's last pixel has been sampled, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame start command |
| roi_x | input | AW | Window first column |
| roi_y | input | AW | Window first row |
| roi_w | input | CW | Window width in pixels |
| roi_h | input | CW | Window height in rows |
| adc_data | input | DW | Converter output word |
| addr_bus | output | AW | Shared start-address bus |
| ld_col | output | 1 | Column start load strobe |
| ld_row | output | 1 | Row start load strobe |
| sync_col | output | 1 | Column shift-register preset |
| sync_row | output | 1 | Row shift-register preset |
| row_clk | output | 1 | Row clock |
| row_reset | output | 1 | Row reset strobe |
| row_select | output | 1 | Row select strobe |
| row_read | output | 1 | Row read strobe |
| side_sel | output | 1 | Side-select strobe |
| cal_pulse | output | 1 | Once-per-frame calibration pulse |
| pix_clk | output | 1 | Pixel clock |
| adc_clk | output | 1 | Converter clock |
| busy | output | 1 | Frame in progress |
| pix_data | output | DW | Captured pixel word |
| pix_valid | output | 1 | Pixel word valid |
| pix_sof | output | 1 | First word of frame |
| pix_eol | output | 1 | Last word of row |

## Verification
The assertions take `frame_start` to be a pulse and the window size to be nonzero whenever a start is accepted. They also take the converter word to hold still from the `adc_clk` fall through its sampling cycle. The bench changes `adc_data` only in the cycle where it sees `pix_clk` fall, using a pattern indexed by pixel, so each word is stable well before capture. Coordinates and sizes are driven only while idle. The one start given during a frame carries different values, so that any effect it had would show in the strobe and pixel counts.

// File: rtl/roi_seq_pkg.sv
package roi_seq_pkg;

   typedef enum logic [4:0] {
      ST_IDLE, ST_ARM,
      ST_YSU, ST_YLD, ST_YHO,
      ST_SYNCY, ST_CALD, ST_CAL,
      ST_RSEL, ST_RSTD, ST_RST, ST_RRD, ST_LRD, ST_LR, ST_CYF,
      ST_XSU, ST_XLD, ST_XHO,
      ST_SYNCX, ST_XHI, ST_XLO
   } seq_st_t;

   localparam int AXIS_X = 0;
   localparam int AXIS_Y = 1;
   localparam int N_AXES = 2;

endpackage

// File: rtl/roi_phase_timer.sv
module roi_phase_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic [TW-1:0] len,
   output logic [TW-1:0] cnt,
   output logic          last
);

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else              cnt <= cnt + 1'b1;
   end

   assign last = (cnt == len - 1'b1);

   AST_TIMER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (last && restart) |=> (cnt == '0)); // R7

endmodule

// File: rtl/roi_start_cache.sv
module roi_start_cache
   import roi_seq_pkg::*;
#(
   parameter int AW = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_AXES-1:0] commit,
   input  logic [AW-1:0]     val_x,
   input  logic [AW-1:0]     val_y,
   output logic [N_AXES-1:0] need
);

   for (genvar a = 0; a < N_AXES; a++) begin : g_axis
      logic [AW-1:0] cur;
      logic [AW-1:0] last_q;
      logic          vld_q;

      assign cur = (a == AXIS_X) ? val_x : val_y;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            last_q <= '0;
            vld_q  <= 1'b0;
         end else if (commit[a]) begin
            last_q <= cur;
            vld_q  <= 1'b1;
         end
      end

      assign need[a] = !vld_q || (last_q != cur);

      AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (commit[a] && $stable(cur)) |=> !need[a]); // R4
   end

endmodule

// File: rtl/roi_pix_out.sv
module roi_pix_out #(
   parameter int DW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap,
   input  logic          first,
   input  logic          last_col,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout,
   output logic          valid,
   output logic          sof,
   output logic          eol
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout  <= '0;
         valid <= 1'b0;
         sof   <= 1'b0;
         eol   <= 1'b0;
      end else begin
         valid <= cap;
         sof   <= cap && first;
         eol   <= cap && last_col;
         if (cap) dout <= din;
      end
   end

   AST_MARK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (sof || eol) |-> valid); // R10

endmodule

// File: rtl/roi_readout_seq.sv
module roi_readout_seq
   import roi_seq_pkg::*;
#(
   parameter int AW       = 10,
   parameter int CW       = 8,
   parameter int DW       = 10,
   parameter int TW       = 8,
   parameter int P_ASU    = 1,
   parameter int P_ALD    = 2,
   parameter int P_AHO    = 1,
   parameter int P_SYNCY  = 50,
   parameter int P_CALD   = 5,
   parameter int P_CALW   = 20,
   parameter int P_SEL    = 10,
   parameter int P_RSTD   = 2,
   parameter int P_RSTW   = 5,
   parameter int P_RD     = 80,
   parameter int P_LRD    = 4,
   parameter int P_LRW    = 10,
   parameter int P_CYF    = 5,
   parameter int P_SX     = 2,
   parameter int P_XH     = 4,
   parameter int P_XL     = 14,
   parameter int P_ADC    = 13,
   parameter int P_CY_MIN = 50
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_start,
   input  logic [AW-1:0] roi_x,
   input  logic [AW-1:0] roi_y,
   input  logic [CW-1:0] roi_w,
   input  logic [CW-1:0] roi_h,
   input  logic [DW-1:0] adc_data,
   output logic [AW-1:0] addr_bus,
   output logic          ld_col,
   output logic          ld_row,
   output logic          sync_col,
   output logic          sync_row,
   output logic          row_clk,
   output logic          row_reset,
   output logic          row_select,
   output logic          row_read,
   output logic          side_sel,
   output logic          cal_pulse,
   output logic          pix_clk,
   output logic          adc_clk,
   output logic          busy,
   output logic [DW-1:0] pix_data,
   output logic          pix_valid,
   output logic          pix_sof,
   output logic          pix_eol
);

   localparam int ROW_HIGH = P_SEL + P_RSTD + P_RSTW + P_RD + P_LRD + P_LRW + P_CYF;
   localparam int LEN_LIM  = 2 ** TW;

   // elaboration-time parameter checks
   if (AW < 1 || CW < 1 || DW < 1) begin : g_bad_width
      $error("roi_readout_seq: widths must be positive");
   end
   if (P_ADC < 1 || P_ADC >= P_XL) begin : g_bad_adc
      $error("roi_readout_seq: capture delay must fit inside the low phase");
   end
   if (ROW_HIGH < P_CY_MIN) begin : g_bad_rowclk
      $error("roi_readout_seq: row clock high time below its minimum");
   end
   if (P_ASU < 1 || P_ALD < 1 || P_AHO < 1 || P_SX < 1 || P_XH < 1 ||
       P_SYNCY < 1 || P_CALD < 1 || P_CALW < 1 || P_SEL < 1 || P_RSTD < 1 ||
       P_RSTW < 1 || P_RD < 1 || P_LRD < 1 || P_LRW < 1 || P_CYF < 1) begin : g_bad_zero
      $error("roi_readout_seq: every phase needs at least one cycle");
   end
   if (P_SYNCY >= LEN_LIM || P_RD >= LEN_LIM || P_CALW >= LEN_LIM ||
       P_XL >= LEN_LIM || P_SEL >= LEN_LIM || P_LRW >= LEN_LIM) begin : g_bad_tw
      $error("roi_readout_seq: phase length exceeds timer width");
   end

   seq_st_t st, nxt;
   logic [AW-1:0] cfg_x, cfg_y, addr_q;
   logic [CW-1:0] cfg_w, cfg_h, row_idx, col_idx;
   logic [TW-1:0] len, cnt;
   logic          t_last, go, adv, last_col, last_row, cap;
   logic [N_AXES-1:0] need, commit;

   assign go  = frame_start && (roi_w != '0) && (roi_h != '0);
   assign adv = (st == ST_IDLE) ? go : t_last;

   always_comb begin
      unique case (st)
         ST_YSU, ST_XSU:   len = TW'(P_ASU);
         ST_YLD, ST_XLD:   len = TW'(P_ALD);
         ST_YHO, ST_XHO:   len = TW'(P_AHO);
         ST_SYNCY:         len = TW'(P_SYNCY);
         ST_CALD:          len = TW'(P_CALD);
         ST_CAL:           len = TW'(P_CALW);
         ST_RSEL:          len = TW'(P_SEL);
         ST_RSTD:          len = TW'(P_RSTD);
         ST_RST:           len = TW'(P_RSTW);
         ST_RRD:           len = TW'(P_RD);
         ST_LRD:           len = TW'(P_LRD);
         ST_LR:            len = TW'(P_LRW);
         ST_CYF:           len = TW'(P_CYF);
         ST_SYNCX:         len = TW'(P_SX);
         ST_XHI:           len = TW'(P_XH);
         ST_XLO:           len = TW'(P_XL);
         default:          len = TW'(1);
      endcase
   end

   roi_phase_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(adv || (st == ST_IDLE)),
      .len(len), .cnt(cnt), .last(t_last)
   );

   assign last_col = (col_idx == cfg_w - 1'b1);
   assign last_row = (row_idx == cfg_h - 1'b1);

   always_comb begin
      nxt = st;
      case (st)
         ST_IDLE:  nxt = ST_ARM;
         ST_ARM:   nxt = need[AXIS_Y] ? ST_YSU : ST_SYNCY;
         ST_YSU:   nxt = ST_YLD;
         ST_YLD:   nxt = ST_YHO;
         ST_YHO:   nxt = ST_SYNCY;
         ST_SYNCY: nxt = ST_CALD;
         ST_CALD:  nxt = ST_CAL;
         ST_CAL:   nxt = ST_RSEL;
         ST_RSEL:  nxt = ST_RSTD;
         ST_RSTD:  nxt = ST_RST;
         ST_RST:   nxt = ST_RRD;
         ST_RRD:   nxt = ST_LRD;
         ST_LRD:   nxt = ST_LR;
         ST_LR:    nxt = ST_CYF;
         ST_CYF:   nxt = (row_idx == '0 && need[AXIS_X]) ? ST_XSU : ST_SYNCX;
         ST_XSU:   nxt = ST_XLD;
         ST_XLD:   nxt = ST_XHO;
         ST_XHO:   nxt = ST_SYNCX;
         ST_SYNCX: nxt = ST_XHI;
         ST_XHI:   nxt = ST_XLO;
         ST_XLO:   nxt = !last_col ? ST_XHI : (last_row ? ST_IDLE : ST_RSEL);
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cfg_x   <= '0;
         cfg_y   <= '0;
         cfg_w   <= '0;
         cfg_h   <= '0;
         row_idx <= '0;
         col_idx <= '0;
         addr_q  <= '0;
      end else if (adv) begin
         st <= nxt;
         if (st == ST_IDLE) begin
            cfg_x   <= roi_x;
            cfg_y   <= roi_y;
            cfg_w   <= roi_w;
            cfg_h   <= roi_h;
            row_idx <= '0;
            col_idx <= '0;
         end
         if (st == ST_XLO) begin
            col_idx <= last_col ? '0 : col_idx + 1'b1;
            if (last_col) row_idx <= row_idx + 1'b1;
         end
         if (nxt == ST_YSU) addr_q <= cfg_y;
         if (nxt == ST_XSU) addr_q <= cfg_x;
      end
   end

   assign commit[AXIS_X] = adv && (st == ST_XHO);
   assign commit[AXIS_Y] = adv && (st == ST_YHO);

   roi_start_cache #(.AW(AW)) u_cache (
      .clk(clk), .rst_n(rst_n), .commit(commit),
      .val_x(cfg_x), .val_y(cfg_y), .need(need)
   );

   assign cap = (st == ST_XLO) && (cnt == TW'(P_ADC));

   roi_pix_out #(.DW(DW)) u_pix (
      .clk(clk), .rst_n(rst_n), .cap(cap),
      .first(row_idx == '0 && col_idx == '0), .last_col(last_col),
      .din(adc_data), .dout(pix_data), .valid(pix_valid),
      .sof(pix_sof), .eol(pix_eol)
   );

   assign addr_bus   = addr_q;
   assign ld_col     = (st == ST_XLD);
   assign ld_row     = (st == ST_YLD);
   assign sync_row   = (st == ST_SYNCY);
   assign cal_pulse  = (st == ST_CAL);
   assign row_clk    = st inside {ST_RSEL, ST_RSTD, ST_RST, ST_RRD, ST_LRD, ST_LR, ST_CYF};
   assign row_select = (st == ST_RSEL);
   assign row_read   = st inside {ST_RSEL, ST_RSTD, ST_RST, ST_RRD};
   assign row_reset  = (st == ST_RST);
   assign side_sel   = (st == ST_LR);
   assign sync_col   = (st == ST_SYNCX);
   assign pix_clk    = st inside {ST_SYNCX, ST_XHI};
   assign adc_clk    = pix_clk;
   assign busy       = (st != ST_IDLE);

   AST_ONE_LOAD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_col && ld_row)); // R3
   AST_BUS_STABLE_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_col || ld_row) |-> $stable(addr_bus)); // R3
   AST_COL_LOAD_OUTSIDE_ROWCLK: assert property (@(posedge clk) disable iff (!rst_n)
      ld_col |-> !row_clk); // R5
   AST_SYNCX_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      sync_col |-> pix_clk); // R8
   AST_SELECT_FALL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(row_select) |-> (row_clk && row_read && !row_reset)); // R7
   AST_SIDE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      side_sel |-> (!row_read && row_clk)); // R7
   AST_CAL_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_pulse) |-> !sync_row); // R6
   AST_PIX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> $past(busy)); // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(row_clk || pix_clk || ld_col || ld_row || sync_row)); // R1

endmodule

// File: tb/tb_roi_readout_seq.sv
module tb_roi_readout_seq;

   localparam int AW = 10, CW = 8, DW = 10;
   localparam int P_ASU = 1, P_ALD = 2, P_AHO = 1, P_SYNCY = 50, P_CALD = 5;
   localparam int P_CALW = 20, P_SEL = 10, P_RSTD = 2, P_RSTW = 5, P_RD = 80;
   localparam int P_LRD = 4, P_LRW = 10, P_CYF = 5, P_SX = 2, P_XH = 4;
   localparam int P_XL = 14, P_ADC = 13;

   logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0;
   logic [AW-1:0] roi_x = '0, roi_y = '0;
   logic [CW-1:0] roi_w = '0, roi_h = '0;
   logic [DW-1:0] adc_data = '0;
   logic [AW-1:0] addr_bus;
   logic ld_col, ld_row, sync_col, sync_row, row_clk, row_reset, row_select;
   logic row_read, side_sel, cal_pulse, pix_clk, adc_clk, busy;
   logic [DW-1:0] pix_data;
   logic pix_valid, pix_sof, pix_eol;

   int n_checks = 0, n_errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   roi_readout_seq #(
      .AW(AW), .CW(CW), .DW(DW), .TW(8),
      .P_ASU(P_ASU), .P_ALD(P_ALD), .P_AHO(P_AHO), .P_SYNCY(P_SYNCY),
      .P_CALD(P_CALD), .P_CALW(P_CALW), .P_SEL(P_SEL), .P_RSTD(P_RSTD),
      .P_RSTW(P_RSTW), .P_RD(P_RD), .P_LRD(P_LRD), .P_LRW(P_LRW),
      .P_CYF(P_CYF), .P_SX(P_SX), .P_XH(P_XH), .P_XL(P_XL), .P_ADC(P_ADC),
      .P_CY_MIN(50)
   ) dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .roi_x(roi_x), .roi_y(roi_y), .roi_w(roi_w), .roi_h(roi_h),
      .adc_data(adc_data), .addr_bus(addr_bus), .ld_col(ld_col), .ld_row(ld_row),
      .sync_col(sync_col), .sync_row(sync_row), .row_clk(row_clk),
      .row_reset(row_reset), .row_select(row_select), .row_read(row_read),
      .side_sel(side_sel), .cal_pulse(cal_pulse), .pix_clk(pix_clk),
      .adc_clk(adc_clk), .busy(busy), .pix_data(pix_data), .pix_valid(pix_valid),
      .pix_sof(pix_sof), .pix_eol(pix_eol)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int k);
      return DW'((k * 37 + 11) & ((1 << DW) - 1));
   endfunction

   // monitor: edge intervals and per-frame counts, sampled at negedge
   int ncyc = 0;
   int exp_x = 0, exp_y = 0, exp_w = 1;
   int t_addr = -1000, t_ld_rise = 0, t_ld_fall = -1000, t_syr_fall = 0, t_syr_rise = 0;
   int t_cal_rise = 0, t_cy_rise = 0, t_sel_fall = 0, t_rst_rise = 0, t_rst_fall = 0;
   int t_rd_fall = 0, t_lr_rise = 0, t_lr_fall = 0, t_px_rise = 0, t_px_fall = 0;
   int t_sx_rise = 0;
   int n_ldx = 0, n_ldy = 0, n_syy = 0, n_cal = 0, n_cy = 0, n_cyf = 0, n_sx = 0;
   int n_pxf = 0, n_val = 0, n_sof = 0, n_eol = 0;
   bit sx_phase = 1'b0;
   logic [AW-1:0] p_addr = '0;
   logic p_ldc = 0, p_ldr = 0, p_syr = 0, p_cal = 0, p_cy = 0, p_sel = 0, p_rst = 0;
   logic p_rd = 0, p_lr = 0, p_px = 0, p_sx = 0;

   always @(negedge clk) begin
      ncyc++;
      if (rst_n) begin
         if (addr_bus != p_addr) begin
            chk(ncyc - t_ld_fall >= P_AHO, "R3 bus hold after strobe", ncyc - t_ld_fall, P_AHO);
            t_addr = ncyc;
         end
         if (ld_col && !p_ldc) begin
            n_ldx++; t_ld_rise = ncyc;
            chk(ncyc - t_addr >= P_ASU, "R3 bus setup before ld_col", ncyc - t_addr, P_ASU);
            chk(int'(addr_bus) == exp_x, "R3 column value on bus", addr_bus, exp_x);
            chk(n_cyf == 1 && n_sx == 0 && !row_clk, "R5 column load slot", n_cyf, 1);
            chk(!ld_row, "R3 strobes exclusive", ld_row, 0);
         end
         if (ld_row && !p_ldr) begin
            n_ldy++; t_ld_rise = ncyc;
            chk(ncyc - t_addr >= P_ASU, "R3 bus setup before ld_row", ncyc - t_addr, P_ASU);
            chk(int'(addr_bus) == exp_y, "R3 row value on bus", addr_bus, exp_y);
            chk(n_syy == 0, "R5 row load before row sync", n_syy, 0);
         end
         if ((!ld_col && p_ldc) || (!ld_row && p_ldr)) begin
            chk(ncyc - t_ld_rise == P_ALD, "R3 strobe width", ncyc - t_ld_rise, P_ALD);
            t_ld_fall = ncyc;
         end
         if (sync_row && !p_syr) begin n_syy++; t_syr_rise = ncyc; end
         if (!sync_row && p_syr) begin
            chk(ncyc - t_syr_rise == P_SYNCY, "R6 row sync width", ncyc - t_syr_rise, P_SYNCY);
            t_syr_fall = ncyc;
         end
         if (cal_pulse && !p_cal) begin
            n_cal++; t_cal_rise = ncyc;
            chk(ncyc - t_syr_fall == P_CALD, "R6 cal delay", ncyc - t_syr_fall, P_CALD);
         end
         if (!cal_pulse && p_cal)
            chk(ncyc - t_cal_rise == P_CALW, "R6 cal width", ncyc - t_cal_rise, P_CALW);
         if (row_clk && !p_cy) begin
            n_cy++; t_cy_rise = ncyc;
            chk(row_select && row_read, "R7 row start strobes", {row_select, row_read}, 3);
         end
         if (!row_select && p_sel) begin
            t_sel_fall = ncyc;
            chk(ncyc - t_cy_rise == P_SEL, "R7 select width", ncyc - t_cy_rise, P_SEL);
         end
         if (row_reset && !p_rst) begin
            t_rst_rise = ncyc;
            chk(ncyc - t_sel_fall == P_RSTD, "R7 reset delay", ncyc - t_sel_fall, P_RSTD);
         end
         if (!row_reset && p_rst) begin
            t_rst_fall = ncyc;
            chk(ncyc - t_rst_rise == P_RSTW, "R7 reset width", ncyc - t_rst_rise, P_RSTW);
         end
         if (!row_read && p_rd) begin
            t_rd_fall = ncyc;
            chk(ncyc - t_rst_fall == P_RD, "R7 read after reset", ncyc - t_rst_fall, P_RD);
         end
         if (side_sel && !p_lr) begin
            t_lr_rise = ncyc;
            chk(ncyc - t_rd_fall == P_LRD, "R7 side delay", ncyc - t_rd_fall, P_LRD);
         end
         if (!side_sel && p_lr) begin
            t_lr_fall = ncyc;
            chk(ncyc - t_lr_rise == P_LRW, "R7 side width", ncyc - t_lr_rise, P_LRW);
         end
         if (!row_clk && p_cy) begin
            n_cyf++;
            chk(ncyc - t_lr_fall == P_CYF, "R7 row clock fall", ncyc - t_lr_fall, P_CYF);
         end
         if (sync_col && !p_sx) begin
            n_sx++; t_sx_rise = ncyc; sx_phase = 1'b1;
            chk(pix_clk && !p_px, "R8 sync rises with pixel clock", pix_clk, 1);
         end
         if (!sync_col && p_sx)
            chk(ncyc - t_sx_rise == P_SX && pix_clk, "R8 column sync width", ncyc - t_sx_rise, P_SX);
         if (pix_clk && !p_px) begin
            if (!sync_col)
               chk(ncyc - t_px_fall == P_XL, "R8 pixel clock low", ncyc - t_px_fall, P_XL);
            t_px_rise = ncyc;
         end
         if (!pix_clk && p_px) begin
            chk(ncyc - t_px_rise == (sx_phase ? P_SX + P_XH : P_XH), "R8 pixel clock high",
                ncyc - t_px_rise, sx_phase ? P_SX + P_XH : P_XH);
            sx_phase = 1'b0;
            t_px_fall = ncyc;
            adc_data <= pat(n_pxf);
            n_pxf++;
         end
         if (pix_clk != p_px)
            chk(adc_clk == pix_clk, "R9 converter clock follows", adc_clk, pix_clk);
         if (pix_valid) begin
            chk(ncyc - t_px_fall == P_ADC + 1, "R9 capture latency", ncyc - t_px_fall, P_ADC + 1);
            chk(pix_data == pat(n_val), "R9 captured word", pix_data, pat(n_val));
            chk(pix_sof == (n_val == 0), "R10 sof mark", pix_sof, n_val == 0);
            chk(pix_eol == ((n_val % exp_w) == exp_w - 1), "R10 eol mark", pix_eol,
                (n_val % exp_w) == exp_w - 1);
            if (pix_sof) n_sof++;
            if (pix_eol) n_eol++;
            n_val++;
         end
      end
      p_addr = addr_bus; p_ldc = ld_col; p_ldr = ld_row; p_syr = sync_row; p_cal = cal_pulse;
      p_cy = row_clk; p_sel = row_select; p_rst = row_reset; p_rd = row_read; p_lr = side_sel;
      p_px = pix_clk; p_sx = sync_col;
   end

   task automatic clear_counts();
      n_ldx = 0; n_ldy = 0; n_syy = 0; n_cal = 0; n_cy = 0; n_cyf = 0; n_sx = 0;
      n_pxf = 0; n_val = 0; n_sof = 0; n_eol = 0;
   endtask

   task automatic run_frame(input int x, input int y, input int w, input int h,
                            input int e_ldx, input int e_ldy, input bit poke);
      @(negedge clk);
      clear_counts();
      exp_x = x; exp_y = y; exp_w = w;
      roi_x = AW'(x); roi_y = AW'(y); roi_w = CW'(w); roi_h = CW'(h);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      chk(busy == 1'b1, "R11 busy after start", busy, 1);
      if (poke) begin
         repeat (100) @(negedge clk);
         roi_x = AW'(x + 100); roi_w = CW'(w + 3);
         frame_start = 1'b1;
         @(negedge clk);
         frame_start = 1'b0;
      end
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(n_ldx == e_ldx, "R4 column strobes", n_ldx, e_ldx);
      chk(n_ldy == e_ldy, "R4 row strobes", n_ldy, e_ldy);
      chk(n_syy == 1, "R6 row sync count", n_syy, 1);
      chk(n_cal == 1, "R6 one cal per frame", n_cal, 1);
      chk(n_cy == h, "R7 row clocks", n_cy, h);
      chk(n_sx == h, "R8 column syncs", n_sx, h);
      chk(n_pxf == w * h, "R8 pixel clock falls", n_pxf, w * h);
      chk(n_val == w * h, "R10 word count", n_val, w * h);
      chk(n_sof == 1, "R10 sof count", n_sof, 1);
      chk(n_eol == h, "R10 eol count", n_eol, h);
      chk(busy == 1'b0, "R11 idle after frame", busy, 0);
      if (poke) begin
         repeat (20) @(negedge clk);
         chk(busy == 1'b0 && n_syy == 1, "R2 start during frame ignored", busy, 0);
      end
   endtask

   task automatic test_reset();
      chk({ld_col, ld_row, sync_col, sync_row, row_clk, row_reset, row_select,
           row_read, side_sel, cal_pulse, pix_clk, adc_clk} == '0, "R1 controls low", 1, 0);
      chk(busy == 1'b0 && pix_valid == 1'b0, "R1 idle flags", busy, 0);
   endtask

   task automatic test_zero_size();
      @(negedge clk);
      clear_counts();
      roi_w = '0; roi_h = CW'(2);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      repeat (10) @(negedge clk);
      chk(busy == 1'b0, "R2 zero width ignored", busy, 0);
      chk(n_syy == 0 && n_ldy == 0, "R2 no activity on zero width", n_syy + n_ldy, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      test_reset();
      run_frame(5, 9, 3, 2, 1, 1, 1'b0);    // first frame: both loads
      run_frame(5, 9, 4, 3, 0, 0, 1'b0);    // unchanged coordinates
      run_frame(17, 9, 2, 2, 1, 0, 1'b1);   // column change, start poked mid-frame
      run_frame(17, 300, 1, 1, 0, 1, 1'b0); // row change, single pixel
      test_zero_size();
      test_reset();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule